// File: doc/BRIEF.md
# Wraparound Tracking Up/Down Counter

This block keeps a local N-bit count that chases a target value sampled from a remote bidirectional counter. The remote count may roll over in either direction, and successive samples can go up or down, but each moves only a little from the one before. Each cycle that brings a new sample moves the local count by a single step toward the target, taking whichever way around the modular ring is shorter. When the local count already matches the target, it holds. Up and down step pulses are registered in the same edge as the count update, so a downstream position accumulator can follow the movement.

The direction is taken from the sign of the wrapping difference `target - count`, read as two's complement. So both the all-ones/zero rollover and the crossing between the largest positive and the largest negative signed code go the short way. A difference of exactly half the range has no shorter side, and the block then steps up. A parameter can select a cheaper decider instead. That decider looks at a 2-bit difference of the top two bits and compares the lower bits only when the two values sit in the same quadrant. The sample input is a plain strobe with no ready. The block accepts a sample on every cycle the strobe is high and cannot apply back-pressure, so the producer never has to wait.

Top module: `wrap_track_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and both `step_up` and `step_dn` are 0.
- R2: On a clock edge where `smp_valid` is low, `count` keeps its value and both step pulses go low.
- R3: On a clock edge where `smp_valid` is high and `target` equals `count`, `count` keeps its value and both step pulses go low.
- R4: On a clock edge where `smp_valid` is high and `(target - count) mod 2^N` lies in 1 to 2^(N-1)-1, `count` increases by one and `step_up` goes high for that cycle.
- R5: On a clock edge where `smp_valid` is high and `(target - count) mod 2^N` lies in 2^(N-1)+1 to 2^N-1, `count` decreases by one and `step_dn` goes high for that cycle.
- R6: Stepping wraps. Up from all ones gives 0, and down from 0 gives all ones.
- R7: If `count` is 2^(N-1)-1 and `target` is 2^(N-1), the count steps up to 2^(N-1). If the roles are swapped, it steps down.
- R8: If the modular difference is exactly 2^(N-1), the count steps up.
- R9: `step_up` and `step_dn` are never high together, and each holds for exactly one cycle per step.
- R10: `at_target` is high in exactly those cycles where the current `count` equals the current `target`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A new target sample is present this cycle |
| target | input | N | Sampled remote count |
| count | output | N | Local tracking count |
| step_up | output | 1 | Count went up by one on the last edge |
| step_dn | output | 1 | Count went down by one on the last edge |
| at_target | output | 1 | Count equals target (combinational) |

## Verification
Two things can coincide in one cycle: a step pulse and the equality flag. This happens when the single step that just occurred lands exactly on a target that holds still. The random phase moves the target by no more than three codes per sample, and it often holds the target steady for several samples. So the count catches up again and again, and on those cycles `step_up` or `step_dn` is high together with `at_target`. The bench's model judges each such cycle. It checks that the pulse reflects the edge just taken, that the flag reflects the present values, and that the next sample produces a hold with both pulses low.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int DIR_FULL_DIFF = 0;
  localparam int DIR_QUADRANT  = 1;
endpackage

// File: rtl/trk_dir_decide.sv
module trk_dir_decide
  import trk_pkg::*;
#(
  parameter int W    = 16,
  parameter int MODE = DIR_FULL_DIFF
) (
  input  logic [W-1:0] target,
  input  logic [W-1:0] cur,
  output step_e        step
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  generate
    if (MODE == DIR_QUADRANT) begin : g_quad
      logic [1:0] qd;
      assign qd = target[W-1:W-2] - cur[W-1:W-2];
      always_comb begin
        case (qd)
          2'b01, 2'b10: step = STEP_UP;    // 2'b10 is half range: tie goes up
          2'b11:        step = STEP_DOWN;
          default: begin
            if (target[W-3:0] > cur[W-3:0])      step = STEP_UP;
            else if (target[W-3:0] < cur[W-3:0]) step = STEP_DOWN;
            else                                 step = STEP_HOLD;
          end
        endcase
      end
    end else begin : g_full
      logic [W-1:0] diff;
      assign diff = target - cur;
      always_comb begin
        if (diff == '0)        step = STEP_HOLD;
        else if (!diff[W-1])   step = STEP_UP;
        else if (diff == HALF) step = STEP_UP;
        else                   step = STEP_DOWN;
      end
    end
  endgenerate
endmodule

// File: rtl/trk_step_reg.sv
module trk_step_reg
  import trk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  step_e        step,
  output logic [W-1:0] cnt_q,
  output logic         up_q,
  output logic         dn_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else if (upd) begin
      case (step)
        STEP_UP: begin
          cnt_q <= cnt_q + 1'b1;
          up_q  <= 1'b1;
          dn_q  <= 1'b0;
        end
        STEP_DOWN: begin
          cnt_q <= cnt_q - 1'b1;
          up_q  <= 1'b0;
          dn_q  <= 1'b1;
        end
        default: begin
          up_q <= 1'b0;
          dn_q <= 1'b0;
        end
      endcase
    end else begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wrap_track_counter.sv
module wrap_track_counter
  import trk_pkg::*;
#(
  parameter int N        = 16,
  parameter int DIR_MODE = DIR_FULL_DIFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [N-1:0] target,
  output logic [N-1:0] count,
  output logic         step_up,
  output logic         step_dn,
  output logic         at_target
);
  initial begin
    if (N < 3) $error("wrap_track_counter: N must be at least 3");
  end

  step_e step_sel;

  trk_dir_decide #(.W(N), .MODE(DIR_MODE)) u_dir (
    .target (target),
    .cur    (count),
    .step   (step_sel)
  );

  trk_step_reg #(.W(N)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (smp_valid),
    .step  (step_sel),
    .cnt_q (count),
    .up_q  (step_up),
    .dn_q  (step_dn)
  );

  assign at_target = (count == target);
endmodule

// File: rtl/wrap_track_counter_chk.sv
module wrap_track_counter_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_valid,
  input logic [N-1:0] target,
  input logic [N-1:0] count,
  input logic         step_up,
  input logic         step_dn,
  input logic         at_target
);
  logic [N-1:0] gap;
  assign gap = target - count;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (count == '0 && !step_up && !step_dn); // R1
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(count) && !step_up && !step_dn); // R2

  AST_EQUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && gap == '0 |=> $stable(count) && !step_up && !step_dn); // R3

  AST_SHORT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && gap != '0 && !gap[N-1] |=> step_up && count == $past(count) + 1'b1); // R4

  AST_SHORT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && gap[N-1] && gap[N-2:0] != '0 |=> step_dn && count == $past(count) - 1'b1); // R5

  AST_HALF_TIE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && gap[N-1] && gap[N-2:0] == '0 |=> step_up); // R8

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn)); // R9

  AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    at_target == (gap == '0)); // R10
endmodule

bind wrap_track_counter wrap_track_counter_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .target    (target),
  .count     (count),
  .step_up   (step_up),
  .step_dn   (step_dn),
  .at_target (at_target)
);

// File: tb/wrap_track_counter_bench.sv
module wrap_track_counter_bench;
  localparam int N = 16;
  localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid = 1'b0;
  logic [N-1:0] target = '0;
  logic [N-1:0] count;
  logic         step_up, step_dn, at_target;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] m_cnt = '0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  wrap_track_counter #(.N(N)) u_wrap_track_counter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .target(target),
    .count(count), .step_up(step_up), .step_dn(step_dn), .at_target(at_target)
  );

  // 1: up, 2: down, 0: hold
  function automatic int ref_dir(logic [N-1:0] t, logic [N-1:0] c);
    logic [N-1:0] d;
    d = t - c;
    if (d == '0) return 0;
    if (d <= HALF) return 1;
    return 2;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(bit v, logic [N-1:0] t, string req);
    int dir;
    @(negedge clk);
    smp_valid = v;
    target = t;
    dir = v ? ref_dir(t, m_cnt) : 0;
    if (dir == 1) m_cnt = m_cnt + 1'b1;
    else if (dir == 2) m_cnt = m_cnt - 1'b1;
    @(posedge clk);
    #1;
    chk(req, count, m_cnt);
    chk(req, step_up, dir == 1);
    chk(req, step_dn, dir == 2);
    chk("R10", at_target, m_cnt == t);
    chk("R9", step_up & step_dn, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", count, 0);
    chk("R1", step_up, 0);
    chk("R1", step_dn, 0);
    @(negedge clk);
    rst_n = 1'b1;

    apply(1'b1, '0, "R3");
    apply(1'b0, 16'h0050, "R2");
    apply(1'b1, 16'hFFFF, "R6");     // 0 -> all ones, down
    apply(1'b1, 16'h0001, "R6");     // all ones -> 0, up
    apply(1'b1, 16'h0001, "R4");
    apply(1'b1, 16'h0001, "R3");
    apply(1'b1, 16'hFFFE, "R5");
    // walk up to the largest positive code
    while (m_cnt != 16'h7FFF) apply(1'b1, 16'h7FFF, "R4");
    apply(1'b1, 16'h8000, "R7");     // mid-range crossing goes up
    apply(1'b1, 16'h7FFF, "R7");     // and back down
    chk("R7", count, 16'h7FFF);
    apply(1'b1, 16'hFFFF, "R8");     // exactly half: tie goes up
    chk("R8", count, 16'h8000);
    apply(1'b1, 16'h0000, "R8");
    apply(1'b0, 16'h1234, "R2");

    // random small-motion phase
    for (int i = 0; i < 3000; i++) begin
      int delta;
      logic [N-1:0] t;
      delta = int'($urandom_range(6)) - 3;
      if ($urandom_range(3) == 0) delta = 0;
      t = target + N'(delta);
      apply($urandom_range(3) != 0, t, "R4/R5 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule